// File: doc/BRIEF.md
# Trace Boundary Selector and Identifier Builder

The block watches committed micro-ops in program order, one per cycle, and decides where each trace begins and ends. A trace opens on the first uop after the previous trace closed. It closes on that uop's control-transfer class or when a size limit is reached. Each closed trace gets a compact identifier: its start address, the ordered taken/not-taken bits of its conditional branches, and the number of those bits.

Consecutive traces with the same identifier and the same length are folded into one. This gives the effect of unrolling a hot loop. The folded trace is described by the identifier of one copy, a repeat count and the total uop count.

A folded trace is held in a one-entry register. It is released as a one-cycle pulse when a trace with a different identifier completes, or when the next copy would push the total past the capacity.

Top module: `trace_sel`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `trace_valid_o` is 0. Reset discards any partial or held trace, so the first trace emitted afterwards starts at the address of the first uop accepted after reset.
- R2: A trace never holds more than 64 uops. The 64th uop always closes the trace, even when it is not a control transfer, and the next uop opens a new trace at that uop's address.
- R3: Kind codes on `uop_kind_i` are 0 conditional branch, 1 direct jump, 2 call, 3 return, 4 indirect jump and 5 software exception. A control transfer of any kind with `uop_taken_i` and `uop_back_i` both high closes the trace. A not-taken backward branch does not close it, and neither does a taken forward branch.
- R4: An indirect jump (kind 4) or a software exception (kind 5) closes the trace regardless of direction.
- R5: A call raises a nesting depth that is zero at trace start. A return at nonzero depth lowers the depth and does not close the trace. A return at depth zero closes the trace.
- R6: Bit i of `trace_dirs_o` is the taken flag of the i-th conditional branch (kind 0) in the trace, counted from 0. `trace_nbits_o` counts those bits, and the bits above that count are 0. The 16th conditional branch closes the trace.
- R7: When a completed trace equals the held one in start, direction bits, bit count and length, and the summed length fits in 64, it is folded in. `trace_len_o` then holds the summed uop count and `trace_reps_o` the number of copies, and nothing is emitted that cycle.
- R8: When folding the next identical copy would exceed 64 uops, the held trace is emitted and the new copy is held with a repeat count of 1.
- R9: The held trace is emitted as a pulse of exactly one cycle. The pulse appears in the cycle after the clock edge that accepts the closing uop of the next, non-folded trace.
- R10: A trace closed by several causes on the same uop (the 64-uop cap together with a backward branch or the 16th conditional) is closed once. That uop is included in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uop_valid_i | input | 1 | A committed uop is presented this cycle |
| uop_pc_i | input | ADDR_W | Address of the uop's instruction |
| uop_cti_i | input | 1 | The uop is a control transfer |
| uop_kind_i | input | 3 | Control-transfer kind code (see R3) |
| uop_taken_i | input | 1 | Control transfer was taken |
| uop_back_i | input | 1 | Target lies below the current address |
| trace_valid_o | output | 1 | One-cycle pulse: emitted trace fields valid |
| trace_start_o | output | ADDR_W | Start address of the emitted trace |
| trace_dirs_o | output | MAXB | Ordered conditional-branch direction bits of one copy |
| trace_nbits_o | output | clog2(MAXB+1) | Number of valid direction bits |
| trace_len_o | output | clog2(CAP+1) | Total uops of the emitted trace |
| trace_reps_o | output | clog2(CAP+1) | Number of identical copies folded together |

## Verification
Two functions can fall in the same cycle. The first case is the 64-uop cap coinciding with a control-transfer close or with the 16th conditional branch on the same uop. The bench provokes it with 63 plain uops followed by a taken backward branch, and with 48 plain uops followed by 16 conditionals. It judges by requiring exactly one emitted trace of length 64 carrying the expected direction bits. The second case is the fold decision meeting the capacity limit while emission of the held trace happens. Loop-body sweeps of 2 and 3 uops over many repeat counts cover it, and the bench predicts the split into full chunks and a remainder arithmetically.

// File: rtl/trace_sel_pkg.sv
`timescale 1ns/1ps
package trace_sel_pkg;
  typedef enum logic [2:0] {
    CTI_COND = 3'd0,
    CTI_JUMP = 3'd1,
    CTI_CALL = 3'd2,
    CTI_RET  = 3'd3,
    CTI_IND  = 3'd4,
    CTI_EXC  = 3'd5
  } cti_kind_e;
endpackage

// File: rtl/tsel_builder.sv
`timescale 1ns/1ps
module tsel_builder
  import trace_sel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CAP     = 64,
  parameter int MAXB    = 16,
  parameter int DEPTH_W = 4,
  localparam int LEN_W  = $clog2(CAP + 1),
  localparam int NB_W   = $clog2(MAXB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uop_valid_i,
  input  logic [ADDR_W-1:0] uop_pc_i,
  input  logic              uop_cti_i,
  input  cti_kind_e         uop_kind_i,
  input  logic              uop_taken_i,
  input  logic              uop_back_i,
  output logic              raw_valid_o,
  output logic [ADDR_W-1:0] raw_start_o,
  output logic [MAXB-1:0]   raw_dirs_o,
  output logic [NB_W-1:0]   raw_nbits_o,
  output logic [LEN_W-1:0]  raw_len_o
);
  logic [ADDR_W-1:0]  start_q;
  logic [LEN_W-1:0]   len_q;
  logic [MAXB-1:0]    dirs_q;
  logic [NB_W-1:0]    nbits_q;
  logic [DEPTH_W-1:0] depth_q;

  logic is_cond, is_call, is_ret, ret_out, cti_end, end_n;
  logic [LEN_W-1:0] len_n;
  logic [MAXB-1:0]  dirs_n;
  logic [NB_W-1:0]  nbits_n;

  always_comb begin
    is_cond = uop_cti_i && (uop_kind_i == CTI_COND);
    is_call = uop_cti_i && (uop_kind_i == CTI_CALL);
    is_ret  = uop_cti_i && (uop_kind_i == CTI_RET);
    ret_out = is_ret && (depth_q == '0);
    len_n   = len_q + LEN_W'(1);
    dirs_n  = dirs_q | (MAXB'(is_cond && uop_taken_i) << nbits_q);
    nbits_n = nbits_q + NB_W'(is_cond);
    cti_end = uop_cti_i && ((uop_kind_i == CTI_IND) || (uop_kind_i == CTI_EXC) ||
                            ret_out || (uop_taken_i && uop_back_i));
    end_n   = (len_n == LEN_W'(CAP)) || (nbits_n == NB_W'(MAXB)) || cti_end;
  end

  assign raw_valid_o = uop_valid_i && end_n;
  assign raw_start_o = (len_q == '0) ? uop_pc_i : start_q;
  assign raw_dirs_o  = dirs_n;
  assign raw_nbits_o = nbits_n;
  assign raw_len_o   = len_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      len_q   <= '0;
      dirs_q  <= '0;
      nbits_q <= '0;
      depth_q <= '0;
    end else if (uop_valid_i) begin
      if (end_n) begin
        len_q   <= '0;
        dirs_q  <= '0;
        nbits_q <= '0;
        depth_q <= '0;
      end else begin
        start_q <= raw_start_o;
        len_q   <= len_n;
        dirs_q  <= dirs_n;
        nbits_q <= nbits_n;
        if (is_call && (depth_q != '1)) depth_q <= depth_q + DEPTH_W'(1);
        else if (is_ret)                depth_q <= depth_q - DEPTH_W'(1);
      end
    end
  end

  // R3
  back_taken_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_i && uop_cti_i && uop_taken_i && uop_back_i |-> raw_valid_o);
  // R5
  outer_ret_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_i && is_ret && (depth_q == '0) |-> raw_valid_o);
  // R5
  nested_ret_pops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_i && is_ret && (depth_q != '0) && !raw_valid_o |=> depth_q == $past(depth_q) - DEPTH_W'(1));
  // R2
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_valid_o |-> (raw_len_o <= LEN_W'(CAP)) && (raw_len_o != '0));
  // R2
  len_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_i && !raw_valid_o |=> len_q == $past(len_q) + LEN_W'(1));
  // R6
  nbits_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_valid_o |-> raw_nbits_o <= NB_W'(MAXB));
endmodule

// File: rtl/tsel_merger.sv
`timescale 1ns/1ps
module tsel_merger #(
  parameter int ADDR_W = 32,
  parameter int CAP    = 64,
  parameter int MAXB   = 16,
  localparam int LEN_W = $clog2(CAP + 1),
  localparam int NB_W  = $clog2(MAXB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_valid_i,
  input  logic [ADDR_W-1:0] raw_start_i,
  input  logic [MAXB-1:0]   raw_dirs_i,
  input  logic [NB_W-1:0]   raw_nbits_i,
  input  logic [LEN_W-1:0]  raw_len_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_start_o,
  output logic [MAXB-1:0]   out_dirs_o,
  output logic [NB_W-1:0]   out_nbits_o,
  output logic [LEN_W-1:0]  out_len_o,
  output logic [LEN_W-1:0]  out_reps_o
);
  logic              pend_v_q;
  logic [ADDR_W-1:0] pend_start_q;
  logic [MAXB-1:0]   pend_dirs_q;
  logic [NB_W-1:0]   pend_nbits_q;
  logic [LEN_W-1:0]  pend_ulen_q, pend_len_q, pend_reps_q;

  logic           same_id, fits, merge;
  logic [LEN_W:0] sum;

  always_comb begin
    sum     = {1'b0, pend_len_q} + {1'b0, raw_len_i};
    same_id = pend_v_q && (pend_start_q == raw_start_i) && (pend_dirs_q == raw_dirs_i) &&
              (pend_nbits_q == raw_nbits_i) && (pend_ulen_q == raw_len_i);
    fits    = sum <= (LEN_W+1)'(CAP);
    merge   = raw_valid_i && same_id && fits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q     <= 1'b0;
      pend_start_q <= '0;
      pend_dirs_q  <= '0;
      pend_nbits_q <= '0;
      pend_ulen_q  <= '0;
      pend_len_q   <= '0;
      pend_reps_q  <= '0;
      out_valid_o  <= 1'b0;
      out_start_o  <= '0;
      out_dirs_o   <= '0;
      out_nbits_o  <= '0;
      out_len_o    <= '0;
      out_reps_o   <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (merge) begin
        pend_len_q  <= sum[LEN_W-1:0];
        pend_reps_q <= pend_reps_q + LEN_W'(1);
      end else if (raw_valid_i) begin
        out_valid_o  <= pend_v_q;
        out_start_o  <= pend_start_q;
        out_dirs_o   <= pend_dirs_q;
        out_nbits_o  <= pend_nbits_q;
        out_len_o    <= pend_len_q;
        out_reps_o   <= pend_reps_q;
        pend_v_q     <= 1'b1;
        pend_start_q <= raw_start_i;
        pend_dirs_q  <= raw_dirs_i;
        pend_nbits_q <= raw_nbits_i;
        pend_ulen_q  <= raw_len_i;
        pend_len_q   <= raw_len_i;
        pend_reps_q  <= LEN_W'(1);
      end
    end
  end

  // R9
  emit_after_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(raw_valid_i));
  // R8
  pend_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_v_q |-> pend_len_q <= LEN_W'(CAP));
  // R7
  reps_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_v_q |-> 32'(pend_len_q) == 32'(pend_ulen_q) * 32'(pend_reps_q));
  // R7
  fold_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge |=> !out_valid_o);
endmodule

// File: rtl/trace_sel.sv
`timescale 1ns/1ps
module trace_sel #(
  parameter int ADDR_W  = 32,
  parameter int CAP     = 64,
  parameter int MAXB    = 16,
  parameter int DEPTH_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        uop_valid_i,
  input  logic [ADDR_W-1:0]           uop_pc_i,
  input  logic                        uop_cti_i,
  input  logic [2:0]                  uop_kind_i,
  input  logic                        uop_taken_i,
  input  logic                        uop_back_i,
  output logic                        trace_valid_o,
  output logic [ADDR_W-1:0]           trace_start_o,
  output logic [MAXB-1:0]             trace_dirs_o,
  output logic [$clog2(MAXB+1)-1:0]   trace_nbits_o,
  output logic [$clog2(CAP+1)-1:0]    trace_len_o,
  output logic [$clog2(CAP+1)-1:0]    trace_reps_o
);
  localparam int LEN_W = $clog2(CAP + 1);
  localparam int NB_W  = $clog2(MAXB + 1);

  logic              raw_valid;
  logic [ADDR_W-1:0] raw_start;
  logic [MAXB-1:0]   raw_dirs;
  logic [NB_W-1:0]   raw_nbits;
  logic [LEN_W-1:0]  raw_len;

  tsel_builder #(.ADDR_W(ADDR_W), .CAP(CAP), .MAXB(MAXB), .DEPTH_W(DEPTH_W)) u_builder (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uop_valid_i (uop_valid_i),
    .uop_pc_i    (uop_pc_i),
    .uop_cti_i   (uop_cti_i),
    .uop_kind_i  (trace_sel_pkg::cti_kind_e'(uop_kind_i)),
    .uop_taken_i (uop_taken_i),
    .uop_back_i  (uop_back_i),
    .raw_valid_o (raw_valid),
    .raw_start_o (raw_start),
    .raw_dirs_o  (raw_dirs),
    .raw_nbits_o (raw_nbits),
    .raw_len_o   (raw_len)
  );

  tsel_merger #(.ADDR_W(ADDR_W), .CAP(CAP), .MAXB(MAXB)) u_merger (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raw_valid_i (raw_valid),
    .raw_start_i (raw_start),
    .raw_dirs_i  (raw_dirs),
    .raw_nbits_i (raw_nbits),
    .raw_len_i   (raw_len),
    .out_valid_o (trace_valid_o),
    .out_start_o (trace_start_o),
    .out_dirs_o  (trace_dirs_o),
    .out_nbits_o (trace_nbits_o),
    .out_len_o   (trace_len_o),
    .out_reps_o  (trace_reps_o)
  );
endmodule

// File: tb/trace_sel_bench.sv
`timescale 1ns/1ps
module trace_sel_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        uop_valid_i = 1'b0;
  logic [31:0] uop_pc_i = '0;
  logic        uop_cti_i = 1'b0;
  logic [2:0]  uop_kind_i = '0;
  logic        uop_taken_i = 1'b0;
  logic        uop_back_i = 1'b0;
  logic        trace_valid_o;
  logic [31:0] trace_start_o;
  logic [15:0] trace_dirs_o;
  logic [4:0]  trace_nbits_o;
  logic [6:0]  trace_len_o, trace_reps_o;

  always #2.5 clk = ~clk;

  trace_sel u_trace_sel (
    .clk_i(clk), .rst_ni(rst_ni), .uop_valid_i(uop_valid_i), .uop_pc_i(uop_pc_i),
    .uop_cti_i(uop_cti_i), .uop_kind_i(uop_kind_i), .uop_taken_i(uop_taken_i),
    .uop_back_i(uop_back_i), .trace_valid_o(trace_valid_o), .trace_start_o(trace_start_o),
    .trace_dirs_o(trace_dirs_o), .trace_nbits_o(trace_nbits_o), .trace_len_o(trace_len_o),
    .trace_reps_o(trace_reps_o)
  );

  int checks = 0, errors = 0, cyc = 0;

  // capture log of emitted traces
  logic [31:0] c_start [1024];
  logic [15:0] c_dirs  [1024];
  logic [4:0]  c_nbits [1024];
  logic [6:0]  c_len   [1024];
  logic [6:0]  c_reps  [1024];
  int c_n = 0;

  always @(negedge clk) begin
    if (rst_ni && trace_valid_o && c_n < 1024) begin
      c_start[c_n] <= trace_start_o;
      c_dirs[c_n]  <= trace_dirs_o;
      c_nbits[c_n] <= trace_nbits_o;
      c_len[c_n]   <= trace_len_o;
      c_reps[c_n]  <= trace_reps_o;
      c_n <= c_n + 1;
    end
  end

  logic [31:0] e_start [16];
  logic [15:0] e_dirs  [16];
  logic [4:0]  e_nbits [16];
  logic [6:0]  e_len   [16];
  logic [6:0]  e_reps  [16];
  int e_n = 0, base = 0;
  string cur_req;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=<150000", cyc);
        summary();
      end
    end
  end

  task automatic send(input logic [31:0] pc, input bit cti, input logic [2:0] kind,
                      input bit tk, input bit bk);
    uop_valid_i = 1'b1; uop_pc_i = pc; uop_cti_i = cti;
    uop_kind_i = kind; uop_taken_i = tk; uop_back_i = bk;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    uop_valid_i = 1'b0; uop_cti_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    uop_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic begin_case(input string req);
    do_reset();
    cur_req = req;
    e_n = 0;
    base = c_n;
  endtask

  task automatic add_exp(input logic [31:0] s, input logic [15:0] d, input int nb,
                         input int len, input int reps);
    e_start[e_n] = s; e_dirs[e_n] = d; e_nbits[e_n] = 5'(nb);
    e_len[e_n] = 7'(len); e_reps[e_n] = 7'(reps);
    e_n++;
  endtask

  task automatic end_case();
    send(32'hF000_0000, 1'b1, 3'd4, 1'b0, 1'b0);
    send(32'hF000_0100, 1'b1, 3'd4, 1'b0, 1'b0);
    add_exp(32'hF000_0000, 16'h0, 0, 1, 1);
    idle(3);
    chk((c_n - base) == e_n, cur_req, "emit count", c_n - base, e_n);
    for (int i = 0; i < e_n && i < (c_n - base); i++) begin
      chk(c_start[base+i] == e_start[i], cur_req, "start", c_start[base+i], e_start[i]);
      chk(c_dirs[base+i]  == e_dirs[i],  cur_req, "dirs",  c_dirs[base+i],  e_dirs[i]);
      chk(c_nbits[base+i] == e_nbits[i], cur_req, "nbits", c_nbits[base+i], e_nbits[i]);
      chk(c_len[base+i]   == e_len[i],   cur_req, "len",   c_len[base+i],   e_len[i]);
      chk(c_reps[base+i]  == e_reps[i],  cur_req, "reps",  c_reps[base+i],  e_reps[i]);
    end
  endtask

  initial begin
    // R1: reset state and reset discarding a partial trace
    do_reset();
    chk(trace_valid_o == 1'b0, "R1", "valid after reset", trace_valid_o, 0);
    begin_case("R1");
    for (int i = 0; i < 3; i++) send(32'h700 + 4*i, 1'b0, 3'd0, 1'b0, 1'b0);
    begin_case("R1");
    chk(trace_valid_o == 1'b0, "R1", "valid after mid-trace reset", trace_valid_o, 0);
    send(32'h800, 1'b1, 3'd4, 1'b0, 1'b0);
    add_exp(32'h800, 16'h0, 0, 1, 1);
    end_case();

    // R2/R4/R10: sweep trace lengths 1..64 closed by an indirect jump
    for (int len = 1; len <= 64; len++) begin
      begin_case("R2");
      for (int i = 0; i < len - 1; i++) send(32'h1000 + 4*i, 1'b0, 3'd0, 1'b0, 1'b0);
      send(32'h1000 + 4*(len-1), 1'b1, 3'd4, 1'b0, 1'b0);
      add_exp(32'h1000, 16'h0, 0, len, 1);
      end_case();
    end

    // R2: cap closes a trace of plain uops; R10 next uop starts new trace
    begin_case("R2");
    for (int i = 0; i < 64; i++) send(32'h2000 + 4*i, 1'b0, 3'd0, 1'b0, 1'b0);
    send(32'h2100, 1'b1, 3'd4, 1'b0, 1'b0);
    add_exp(32'h2000, 16'h0, 0, 64, 1);
    add_exp(32'h2100, 16'h0, 0, 1, 1);
    end_case();

    // R10: cap coincides with taken backward branch
    begin_case("R10");
    for (int i = 0; i < 63; i++) send(32'h2400 + 4*i, 1'b0, 3'd0, 1'b0, 1'b0);
    send(32'h24FC, 1'b1, 3'd0, 1'b1, 1'b1);
    send(32'h2600, 1'b1, 3'd5, 1'b0, 1'b0);
    add_exp(32'h2400, 16'h1, 1, 64, 1);
    add_exp(32'h2600, 16'h0, 0, 1, 1);
    end_case();

    // R10: cap coincides with the 16th conditional branch
    begin_case("R10");
    for (int i = 0; i < 48; i++) send(32'h2800 + 4*i, 1'b0, 3'd0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) send(32'h28C0 + 4*i, 1'b1, 3'd0, 1'b1, 1'b0);
    add_exp(32'h2800, 16'hFFFF, 16, 64, 1);
    end_case();

    // R3: not-taken backward and taken forward do not close; taken backward jump does
    begin_case("R3");
    send(32'h100, 1'b0, 3'd0, 1'b0, 1'b0);
    send(32'h104, 1'b1, 3'd0, 1'b0, 1'b1);
    send(32'h108, 1'b1, 3'd0, 1'b1, 1'b0);
    send(32'h10C, 1'b1, 3'd1, 1'b1, 1'b1);
    add_exp(32'h100, 16'h2, 2, 4, 1);
    end_case();

    // R4: forward taken jump continues, software exception closes
    begin_case("R4");
    send(32'h400, 1'b0, 3'd0, 1'b0, 1'b0);
    send(32'h404, 1'b1, 3'd1, 1'b1, 1'b0);
    send(32'h440, 1'b1, 3'd5, 1'b0, 1'b0);
    add_exp(32'h400, 16'h0, 0, 3, 1);
    end_case();

    // R5: nested return continues, outermost return closes
    begin_case("R5");
    send(32'h500, 1'b0, 3'd0, 1'b0, 1'b0);
    send(32'h504, 1'b1, 3'd2, 1'b1, 1'b0);
    send(32'h900, 1'b0, 3'd0, 1'b0, 1'b0);
    send(32'h904, 1'b1, 3'd3, 1'b1, 1'b0);
    send(32'h508, 1'b1, 3'd3, 1'b1, 1'b0);
    add_exp(32'h500, 16'h0, 0, 5, 1);
    end_case();

    begin_case("R5");
    send(32'h520, 1'b1, 3'd2, 1'b1, 1'b0);
    send(32'hA00, 1'b1, 3'd2, 1'b1, 1'b0);
    send(32'hB00, 1'b1, 3'd3, 1'b1, 1'b0);
    send(32'hA04, 1'b1, 3'd3, 1'b1, 1'b0);
    send(32'h524, 1'b1, 3'd3, 1'b1, 1'b0);
    add_exp(32'h520, 16'h0, 0, 5, 1);
    end_case();

    // R6: direction bits for 0..16 conditional branches
    for (int k = 0; k <= 16; k++) begin
      logic [15:0] p, m;
      p = 16'h9E37 ^ 16'(k * 613);
      m = 16'((32'h1 << k) - 1);
      begin_case("R6");
      for (int i = 0; i < k; i++) send(32'h3000 + 4*i, 1'b1, 3'd0, p[i], 1'b0);
      if (k < 16) begin
        send(32'h3000 + 4*k, 1'b1, 3'd4, 1'b0, 1'b0);
        add_exp(32'h3000, p & m, k, k + 1, 1);
      end else begin
        add_exp(32'h3000, p, 16, 16, 1);
      end
      end_case();
    end

    // R7/R8: loop bodies of 2 and 3 uops repeated n times
    for (int b = 2; b <= 3; b++) begin
      for (int n = 1; n <= (b == 2 ? 40 : 25); n++) begin
        int per, full, rem;
        per = 64 / b; full = n / per; rem = n % per;
        begin_case(n > per ? "R8" : "R7");
        for (int r = 0; r < n; r++) begin
          for (int i = 0; i < b - 1; i++) send(32'h200 + 4*i, 1'b0, 3'd0, 1'b0, 1'b0);
          send(32'h200 + 4*(b-1), 1'b1, 3'd0, 1'b1, 1'b1);
        end
        for (int f = 0; f < full; f++) add_exp(32'h200, 16'h1, 1, per * b, per);
        if (rem != 0) add_exp(32'h200, 16'h1, 1, rem * b, rem);
        end_case();
      end
    end

    // R7: same start, different directions do not fold
    begin_case("R7");
    for (int r = 0; r < 3; r++) begin
      send(32'h600, 1'b1, 3'd0, (r != 1), 1'b0);
      send(32'h604, 1'b1, 3'd1, 1'b1, 1'b1);
      add_exp(32'h600, (r != 1) ? 16'h1 : 16'h0, 1, 2, 1);
    end
    end_case();

    // R9: pulse timing and width
    begin_case("R9");
    send(32'h10, 1'b1, 3'd4, 1'b0, 1'b0);
    chk(trace_valid_o == 1'b0, "R9", "no emit on first trace", trace_valid_o, 0);
    send(32'h20, 1'b1, 3'd4, 1'b0, 1'b0);
    chk(trace_valid_o == 1'b1, "R9", "emit after second trace", trace_valid_o, 1);
    chk(trace_start_o == 32'h10, "R9", "emitted start", trace_start_o, 32'h10);
    idle(1);
    chk(trace_valid_o == 1'b0, "R9", "pulse one cycle", trace_valid_o, 0);
    add_exp(32'h10, 16'h0, 0, 1, 1);
    add_exp(32'h20, 16'h0, 0, 1, 1);
    end_case();

    summary();
  end
endmodule